// File: doc/BRIEF.md
# USB Microframe Index and SOF Counter

This block keeps the periodic frame index of a high-speed USB host controller together with the frame number placed in each start-of-frame token. A 125 µs tick advances a 14-bit index. Its low three bits count the eight microframes of a 1 ms frame, and its upper eleven bits count frames. A separate 11-bit start-of-frame value runs one microframe behind the frame field. As a result, the bus sees eight tokens in a row with the same number, and those eight straddle the host's own frame boundary by one microframe.

Each accepted tick produces a one-cycle strobe that asks the token generator to send a start-of-frame carrying the current value. Software can load the index at any time. The shadow value is then set so that the one-microframe lag still holds. Token serialization and CRC generation belong to the neighbouring logic.

Top module: `mfidx_sof_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the index becomes 0, the start-of-frame value becomes 2047 (all ones), and the strobe is 0.
- R2: A tick accepted while `run_en` is high and `load_en` is low advances the microframe field `frame_idx[2:0]` by one, wrapping from 7 to 0.
- R3: The frame field `frame_idx[13:3]` changes on a tick only when the microframe field wraps from 7 to 0, and it then increases by one.
- R4: The start-of-frame value increases by one when the microframe field passes from 0 to 1. At all times out of reset, it equals the frame field minus one (modulo 2048) when the microframe field is 0, and it equals the frame field otherwise.
- R5: `sof_stb` is high for exactly the one cycle after each accepted tick. In that cycle `sof_value` already shows the value as updated by that tick, so eight consecutive strobes carry the same number.
- R6: While `run_en` is low, ticks are ignored: the index and the start-of-frame value hold and no strobe is issued.
- R7: A load sets the index to `load_idx` in the next cycle. It sets the start-of-frame value to `load_idx[13:3]`, minus one when `load_idx[2:0]` is 0. A load wins over a tick in the same cycle and produces no strobe.
- R8: The frame field and the start-of-frame value both wrap modulo 2048 with no error indication. From index 16383, a tick gives index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Allows ticks to advance the counters |
| uf_tick | input | 1 | One-cycle 125 µs microframe tick |
| load_en | input | 1 | Software load of the index |
| load_idx | input | 14 | Index value to load |
| frame_idx | output | 14 | Frame index: [13:3] frame, [2:0] microframe |
| sof_value | output | 11 | Frame number for the start-of-frame token |
| sof_stb | output | 1 | One-cycle start-of-frame request |

## Verification
A microframe field that skips or repeats is visible on `frame_idx` in the cycle after the offending tick. A bad carry or a wrong shadow step breaks the fixed relation between `sof_value` and the frame field, and that relation is compared after every cycle. An error in the shadow counter therefore shows at most one tick later, at the next 0-to-1 microframe step. A wrong load offset for a zero microframe field, or a strobe leaking from an ignored or overridden tick, shows in the cycle directly after the load or tick.

// File: rtl/mfidx_pkg.sv
// Shared widths for the microframe index block.
// Assumes the high-speed layout: 3 microframe bits under 11 frame bits.
package mfidx_pkg;
    localparam int unsigned UF_W_DEF    = 3;
    localparam int unsigned FRAME_W_DEF = 11;
endpackage

// File: rtl/mfidx_uframe_ctr.sv
// Microframe field counter.
// Counts accepted ticks modulo 2**UF_W and reports two events: a wrap of the
// top code back to zero (the carry into the frame field) and a step away
// from zero (the trigger for the start-of-frame shadow).
// Assumes the caller has already removed ticks that collide with a load.
module mfidx_uframe_ctr #(
    parameter int unsigned UF_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            ld,
    input  logic [UF_W-1:0] ld_val,
    output logic [UF_W-1:0] uf,
    output logic            wrap,
    output logic            leave0
);
    localparam logic [UF_W-1:0] UF_ZERO = '0;
    localparam logic [UF_W-1:0] UF_ONE  = {{(UF_W-1){1'b0}}, 1'b1};

    // Microframe register: reset, load, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)   uf <= UF_ZERO;
        else if (ld)  uf <= ld_val;
        else if (adv) uf <= uf + UF_ONE;
    end

    // Carry out on the wrap from the top code to zero.
    always_comb wrap   = adv && (&uf);
    // Zero-to-one step that moves the shadow frame number.
    always_comb leave0 = adv && (uf == UF_ZERO);
endmodule

// File: rtl/mfidx_wrap_ctr.sv
// Loadable modulo-2**W counter with a parameterized reset value.
// Used for both the frame field and the start-of-frame shadow value.
// Assumes load has priority over increment; it wraps silently.
module mfidx_wrap_ctr #(
    parameter int unsigned W = 11,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

    // Counter register: reset, load, or wrap-around increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + STEP;
    end
endmodule

// File: rtl/mfidx_sof_counter.sv
// Periodic frame index with a lagging start-of-frame shadow counter.
// The index advances on each accepted microframe tick. The frame field steps on
// the microframe carry, and the shadow value steps when the microframe field
// leaves zero, so the shadow trails the frame field by one microframe.
// Assumes uf_tick is a single-cycle pulse in the clk domain.
module mfidx_sof_counter
    import mfidx_pkg::*;
#(
    parameter int unsigned UF_W    = UF_W_DEF,
    parameter int unsigned FRAME_W = FRAME_W_DEF,
    localparam int unsigned IDX_W  = UF_W + FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               uf_tick,
    input  logic               load_en,
    input  logic [IDX_W-1:0]   load_idx,
    output logic [IDX_W-1:0]   frame_idx,
    output logic [FRAME_W-1:0] sof_value,
    output logic               sof_stb
);
    localparam logic [FRAME_W-1:0] SOF_RST = '1;
    localparam logic [UF_W-1:0]    UF_ZERO = '0;

    logic               adv;
    logic               uf_wrap;
    logic               uf_leave0;
    logic [UF_W-1:0]    uf_q;
    logic [FRAME_W-1:0] frm_q;
    logic [FRAME_W-1:0] ld_frame;
    logic [FRAME_W-1:0] ld_sof;

    // Accepted tick: running and not overridden by a load.
    always_comb adv = uf_tick && run_en && !load_en;

    // Split the load value and derive the shadow value that keeps the lag.
    always_comb begin
        ld_frame = load_idx[IDX_W-1:UF_W];
        ld_sof   = ld_frame - {{(FRAME_W-1){1'b0}}, (load_idx[UF_W-1:0] == UF_ZERO)};
    end

    mfidx_uframe_ctr #(.UF_W(UF_W)) u_uf (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .ld     (load_en),
        .ld_val (load_idx[UF_W-1:0]),
        .uf     (uf_q),
        .wrap   (uf_wrap),
        .leave0 (uf_leave0)
    );

    mfidx_wrap_ctr #(.W(FRAME_W), .RST_VAL('0)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (uf_wrap),
        .ld     (load_en),
        .ld_val (ld_frame),
        .q      (frm_q)
    );

    mfidx_wrap_ctr #(.W(FRAME_W), .RST_VAL(SOF_RST)) u_sof (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (uf_leave0),
        .ld     (load_en),
        .ld_val (ld_sof),
        .q      (sof_value)
    );

    // Start-of-frame request: one cycle after each accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) sof_stb <= 1'b0;
        else        sof_stb <= adv;
    end

    // Assemble the visible index from its two fields.
    always_comb frame_idx = {frm_q, uf_q};
endmodule

// File: rtl/mfidx_sof_counter_chk.sv
// Property checker for mfidx_sof_counter, attached by bind.
// Observes ports only; assumes the default 3/11 field split.
module mfidx_sof_counter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run_en,
    input logic        uf_tick,
    input logic        load_en,
    input logic [13:0] load_idx,
    input logic [13:0] frame_idx,
    input logic [10:0] sof_value,
    input logic        sof_stb
);
    // R2
    uf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_tick && run_en && !load_en) |=> (frame_idx[2:0] == $past(frame_idx[2:0]) + 3'd1));

    // R3
    frame_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !(uf_tick && run_en && frame_idx[2:0] == 3'd7)) |=> $stable(frame_idx[13:3]));

    // R4
    sof_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_value == (frame_idx[13:3] - {10'd0, (frame_idx[2:0] == 3'd0)}));

    // R5
    stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_stb |-> $past(uf_tick && run_en && !load_en));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_en) |=> ($stable(frame_idx) && $stable(sof_value) && !sof_stb));

    // R7
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (frame_idx == $past(load_idx) && !sof_stb));
endmodule

bind mfidx_sof_counter mfidx_sof_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .uf_tick   (uf_tick),
    .load_en   (load_en),
    .load_idx  (load_idx),
    .frame_idx (frame_idx),
    .sof_value (sof_value),
    .sof_stb   (sof_stb)
);

// File: tb/sim_mfidx_sof_counter.sv
// Scoreboard bench: the driver applies one cycle of stimulus and queues the
// expected outputs; the monitor compares them after the following edge.
module sim_mfidx_sof_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        uf_tick = 1'b0;
    logic        load_en = 1'b0;
    logic [13:0] load_idx = '0;
    logic [13:0] frame_idx;
    logic [10:0] sof_value;
    logic        sof_stb;

    typedef struct {
        logic [13:0] idx;
        logic [10:0] sof;
        logic        stb;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    logic [13:0] m_idx = '0;
    bit   done = 0;

    always #10 clk = ~clk;

    mfidx_sof_counter u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .uf_tick(uf_tick),
        .load_en(load_en), .load_idx(load_idx),
        .frame_idx(frame_idx), .sof_value(sof_value), .sof_stb(sof_stb)
    );

    // Shadow value required by R4, from the index alone.
    function automatic logic [10:0] lag_of(input logic [13:0] i);
        return i[13:3] - {10'd0, (i[2:0] == 3'd0)};
    endfunction

    task automatic step(input bit r, input bit run, input bit tk,
                        input bit ld, input logic [13:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = ~r; run_en = run; uf_tick = tk; load_en = ld; load_idx = v;
        e.stb = 1'b0;
        if (r) begin
            m_idx = '0;
            e.sof = 11'h7FF;
        end else if (ld) begin
            m_idx = v;
            e.sof = lag_of(m_idx);
        end else if (tk && run) begin
            m_idx = m_idx + 14'd1;
            e.sof = lag_of(m_idx);
            e.stb = 1'b1;
        end else begin
            e.sof = lag_of(m_idx);
        end
        e.idx = m_idx;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after each edge.
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (frame_idx !== e.idx) begin
                errors++;
                $display("FAIL %s frame_idx actual %h expected %h", e.tag, frame_idx, e.idx);
            end
            checks++;
            if (sof_value !== e.sof) begin
                errors++;
                $display("FAIL %s sof_value actual %h expected %h", e.tag, sof_value, e.sof);
            end
            checks++;
            if (sof_stb !== e.stb) begin
                errors++;
                $display("FAIL %s sof_stb actual %b expected %b", e.tag, sof_stb, e.stb);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a tick present that must be ignored
        step(1, 1, 1, 0, '0, "R1");
        step(1, 0, 0, 0, '0, "R1");
        // R2 R3 R4 R5: run through more than two frames, tick every other cycle
        for (int k = 0; k < 20; k++) begin
            step(0, 1, 1, 0, '0, "R2/R3/R4/R5");
            step(0, 1, 0, 0, '0, "R5");
        end
        // R5: back-to-back ticks
        for (int k = 0; k < 9; k++) step(0, 1, 1, 0, '0, "R5");
        // R6: ticks while not running
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, '0, "R6");
        // R7: load with nonzero microframe field
        step(0, 1, 0, 1, 14'h0123, "R7");
        step(0, 1, 1, 0, '0, "R4");
        // R7: load with zero microframe field colliding with a tick
        step(0, 1, 1, 1, 14'h0128, "R7");
        step(0, 1, 1, 0, '0, "R4");
        // R7: load of zero while stopped gives shadow 2047
        step(0, 0, 0, 1, 14'h0000, "R7");
        // R8: wrap of both counters
        step(0, 1, 0, 1, 14'h3FFE, "R8");
        for (int k = 0; k < 4; k++) step(0, 1, 1, 0, '0, "R8");
        step(0, 1, 0, 0, '0, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule